// File: doc/BRIEF.md
# I2C Master Receive Byte Counter and Bus Hold Control

This block is the receive-side flow control of an I2C master. Software loads a remaining-byte count, then requests a transfer. A bit-level shifter, outside this block, hands over each received byte as a one-cycle byte strobe. The block decides whether that byte is to be acknowledged, stores it in a small first-in first-out buffer, and lowers the count. The count alone ends the transfer. The byte that takes the count from one to zero is answered with a not-acknowledge, whatever the hold setting is.

A hold setting keeps the bus owned after the count runs out, so that the next request can begin with a repeated start rather than a stop. While hold is set and the buffer is full, the block asks the shifter to stretch the clock. It raises a one-cycle level pulse when the buffer fill reaches two short of full. It raises a one-cycle completion pulse when the final byte of a transfer is stored with hold clear. Overflow and underflow of the buffer each give their own one-cycle pulse.

The sequencer has three states. In idle, a start request with a non-zero count takes the start transition into receive. In receive, storing the last byte takes the finish transition: to idle when hold is clear, or to park when hold is set. In park the bus stays owned. A start request with a non-zero count takes the repeated-start transition back to receive. Clearing hold takes the release transition to idle.

Top module: `i2c_rx_flow_ctl`

## Requirements
- R1: After reset the bus is not busy, the remaining count is 0, no data is available, stall is low, acknowledge is low and all four pulses are low.
- R2: A count write loads `xfer_left` on the next edge. A start request with a non-zero count raises `bus_busy`. A start request with a zero count is ignored.
- R3: Each byte strobe in the receive state lowers the count by one. A byte strobe outside the receive state leaves both the count and the buffer unchanged.
- R4: `rx_ack` is high while the count is above 1 and low when the count is 1 or 0. A count of 1 gives a not-acknowledge even with hold set.
- R5: When the byte that takes the count to zero is stored with hold clear, the block returns to idle and `done_irq` is high for exactly the one cycle after that edge.
- R6: When the count ends with hold set, `bus_busy` stays high and no completion pulse is given. A start request while parked re-enters receive without dropping `bus_busy`. Clearing hold while parked releases the bus without a completion pulse.
- R7: The buffer holds 16 bytes and returns them in arrival order. `rd_data` shows the oldest byte before the read. `rx_avail` is high exactly while the buffer is not empty.
- R8: `lvl_irq` pulses for one cycle each time a stored byte raises the fill to 14.
- R9: `scl_stall` is high while hold is set and the buffer is full. It falls after the edge on which one byte is read. It stays low with hold clear.
- R10: A byte that arrives while the buffer is full, with no read in the same cycle, is dropped and raises `ovf_irq` for one cycle. It still lowers the count, and the stored bytes are untouched.
- R11: A read while the buffer is empty raises `unf_irq` for one cycle and leaves the buffer empty.
- R12: A clear request empties the buffer by the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Load the remaining-byte count |
| cfg_size | input | 8 | Count value to load |
| hold_en | input | 1 | Keep the bus owned after the count ends; stretch when full |
| fifo_clr | input | 1 | Empty the receive buffer |
| start_req | input | 1 | Start (or repeated-start) request |
| byte_vld | input | 1 | One-cycle strobe: a byte has been received |
| byte_data | input | 8 | Received byte |
| rd_en | input | 1 | Pop the oldest byte |
| rd_data | output | 8 | Oldest stored byte |
| rx_ack | output | 1 | 1 = acknowledge the byte now arriving, 0 = not-acknowledge |
| scl_stall | output | 1 | Request to stretch the bus clock |
| rx_avail | output | 1 | Buffer not empty |
| bus_busy | output | 1 | Bus owned (receive or park state) |
| xfer_left | output | 8 | Remaining byte count |
| lvl_irq | output | 1 | Fill reached 14 (pulse) |
| done_irq | output | 1 | Transfer completed with hold clear (pulse) |
| ovf_irq | output | 1 | Byte dropped on a full buffer (pulse) |
| unf_irq | output | 1 | Read of an empty buffer (pulse) |

## Verification
The main receive path is run with transfers of 1, 5, 14 and 16 bytes, with hold both set and clear. Together these separate a single-byte not-acknowledge, the absence of a level pulse below 14, the exact level threshold, and the full-buffer stall. Each choice of hold also shows whether completion comes with a stop or the bus is parked. Directed runs then cover a 20-byte read that overflows the buffer with hold clear, a 17-byte read with hold set that stalls and is relieved by one read, and a repeated start from park. They also cover byte strobes and reads while idle, and the buffer clear.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_RECV = 2'd1,
        RX_PARK = 2'd2
    } rx_state_e;

endpackage

// File: rtl/i2c_rx_fifo.sv
module i2c_rx_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    parameter int MARK  = DEPTH - 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        push,
    input  logic                        pop_req,
    input  logic [DW-1:0]               wdata,
    output logic [DW-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0]  level,
    output logic                        empty,
    output logic                        full,
    output logic                        ovf_p,
    output logic                        unf_p,
    output logic                        mark_p
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          pop, push_ok;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign pop     = pop_req && !empty && !clr;
    assign push_ok = push && (!full || pop) && !clr;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
            ovf_p  <= 1'b0;
            unf_p  <= 1'b0;
            mark_p <= 1'b0;
        end else begin
            ovf_p  <= push && !push_ok && !clr;
            unf_p  <= pop_req && empty && !clr;
            mark_p <= push_ok && !pop && (level == LW'(MARK - 1));
            if (clr) begin
                wr_ptr <= '0;
                rd_ptr <= '0;
                level  <= '0;
            end else begin
                if (push_ok) wr_ptr <= bump(wr_ptr);
                if (pop)     rd_ptr <= bump(rd_ptr);
                level <= level + LW'(push_ok) - LW'(pop);
            end
        end
    end
endmodule

// File: rtl/i2c_rx_bytecnt.sv
module i2c_rx_bytecnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          last,
    output logic          zero
);
    assign zero = (count == '0);
    assign last = (count == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (dec && !zero) begin
            count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/i2c_rx_seq.sv
module i2c_rx_seq
    import i2c_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      hold,
    input  logic      byte_vld,
    input  logic      cnt_zero,
    input  logic      cnt_last,
    output rx_state_e st_o,
    output logic      accept,
    output logic      busy,
    output logic      done_set
);
    rx_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RX_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RX_IDLE: begin
                if (start && !cnt_zero) st_d = RX_RECV;
            end
            RX_RECV: begin
                if (cnt_zero || (byte_vld && cnt_last)) begin
                    st_d = hold ? RX_PARK : RX_IDLE;
                end
            end
            RX_PARK: begin
                if (start && !cnt_zero) st_d = RX_RECV;
                else if (!hold)         st_d = RX_IDLE;
            end
            default: st_d = RX_IDLE;
        endcase
    end

    always_comb begin
        st_o     = st_q;
        accept   = (st_q == RX_RECV) && byte_vld && !cnt_zero;
        busy     = (st_q != RX_IDLE);
        done_set = accept && cnt_last && !hold;
    end
endmodule

// File: rtl/i2c_rx_flow_ctl.sv
module i2c_rx_flow_ctl
    import i2c_rx_pkg::*;
#(
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic [CW-1:0] cfg_size,
    input  logic          hold_en,
    input  logic          fifo_clr,
    input  logic          start_req,
    input  logic          byte_vld,
    input  logic [DW-1:0] byte_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rx_ack,
    output logic          scl_stall,
    output logic          rx_avail,
    output logic          bus_busy,
    output logic [CW-1:0] xfer_left,
    output logic          lvl_irq,
    output logic          done_irq,
    output logic          ovf_irq,
    output logic          unf_irq
);
    localparam int MARK = DEPTH - 2;
    localparam int LW   = $clog2(DEPTH + 1);

    rx_state_e     st_q;
    logic          accept, done_set;
    logic          cnt_zero, cnt_last;
    logic          fifo_empty, fifo_full;
    logic [LW-1:0] fifo_level;

    i2c_rx_bytecnt #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_wr),
        .load_val (cfg_size),
        .dec      (accept),
        .count    (xfer_left),
        .last     (cnt_last),
        .zero     (cnt_zero)
    );

    i2c_rx_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_req),
        .hold     (hold_en),
        .byte_vld (byte_vld),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last),
        .st_o     (st_q),
        .accept   (accept),
        .busy     (bus_busy),
        .done_set (done_set)
    );

    i2c_rx_fifo #(.DW(DW), .DEPTH(DEPTH), .MARK(MARK)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (fifo_clr),
        .push    (accept),
        .pop_req (rd_en),
        .wdata   (byte_data),
        .rdata   (rd_data),
        .level   (fifo_level),
        .empty   (fifo_empty),
        .full    (fifo_full),
        .ovf_p   (ovf_irq),
        .unf_p   (unf_irq),
        .mark_p  (lvl_irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_irq <= 1'b0;
        end else begin
            done_irq <= done_set;
        end
    end

    assign rx_ack    = !cnt_zero && !cnt_last;
    assign scl_stall = hold_en && fifo_full;
    assign rx_avail  = !fifo_empty;
endmodule

// File: rtl/i2c_rx_flow_chk.sv
module i2c_rx_flow_chk
    import i2c_rx_pkg::*;
#(
    parameter int CW    = 8,
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst_n,
    input rx_state_e                  state,
    input logic                       byte_vld,
    input logic                       cfg_wr,
    input logic                       rd_en,
    input logic                       hold_en,
    input logic                       rx_ack,
    input logic [CW-1:0]              xfer_left,
    input logic [$clog2(DEPTH+1)-1:0] level,
    input logic                       scl_stall,
    input logic                       rx_avail,
    input logic                       bus_busy,
    input logic                       done_irq,
    input logic                       ovf_irq,
    input logic                       unf_irq,
    input logic                       lvl_irq
);
    localparam int LW = $clog2(DEPTH + 1);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECV && byte_vld && xfer_left != '0 && !cfg_wr)
        |=> xfer_left == CW'($past(xfer_left) - 1'b1));

    assert_nack_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_RECV && byte_vld && !rx_ack && xfer_left != '0 && !cfg_wr)
        |=> xfer_left == '0);

    assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !bus_busy);

    assert_done_no_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> !$past(hold_en));

    assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    assert_mark_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_irq |-> level == LW'(DEPTH - 2));

    assert_stall_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_stall |-> rx_avail);

    assert_ovf_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> $past(level) == LW'(DEPTH));

    assert_unf_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unf_irq |-> ($past(rd_en) && !$past(rx_avail)));
endmodule

bind i2c_rx_flow_ctl i2c_rx_flow_chk #(.CW(CW), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (st_q),
    .byte_vld  (byte_vld),
    .cfg_wr    (cfg_wr),
    .rd_en     (rd_en),
    .hold_en   (hold_en),
    .rx_ack    (rx_ack),
    .xfer_left (xfer_left),
    .level     (fifo_level),
    .scl_stall (scl_stall),
    .rx_avail  (rx_avail),
    .bus_busy  (bus_busy),
    .done_irq  (done_irq),
    .ovf_irq   (ovf_irq),
    .unf_irq   (unf_irq),
    .lvl_irq   (lvl_irq)
);

// File: tb/i2c_rx_flow_ctl_test.sv
module i2c_rx_flow_ctl_test;
    localparam int CLK_PERIOD = 10;
    // each entry: {size, hold, expected level pulses, expected completion pulses}
    localparam logic [10:0] VEC [4] = '{
        {8'd1,  1'b0, 1'b0, 1'b1},
        {8'd5,  1'b1, 1'b0, 1'b0},
        {8'd14, 1'b0, 1'b1, 1'b1},
        {8'd16, 1'b1, 1'b1, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n, cfg_wr, hold_en, fifo_clr, start_req, byte_vld, rd_en;
    logic [7:0] cfg_size, byte_data, rd_data, xfer_left;
    logic       rx_ack, scl_stall, rx_avail, bus_busy;
    logic       lvl_irq, done_irq, ovf_irq, unf_irq;

    int checks = 0, failures = 0;
    int acks, done_seen, lvl_seen;
    logic last_ack;

    i2c_rx_flow_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size(cfg_size),
        .hold_en(hold_en), .fifo_clr(fifo_clr), .start_req(start_req),
        .byte_vld(byte_vld), .byte_data(byte_data), .rd_en(rd_en),
        .rd_data(rd_data), .rx_ack(rx_ack), .scl_stall(scl_stall),
        .rx_avail(rx_avail), .bus_busy(bus_busy), .xfer_left(xfer_left),
        .lvl_irq(lvl_irq), .done_irq(done_irq), .ovf_irq(ovf_irq),
        .unf_irq(unf_irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_count(input logic [7:0] n);
        cfg_wr = 1'b1; cfg_size = n; tick(); cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start_req = 1'b1; tick(); start_req = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        byte_vld = 1'b1; byte_data = d;
        last_ack = rx_ack;
        if (rx_ack) acks++;
        tick();
        byte_vld = 1'b0;
        if (done_irq) done_seen++;
        if (lvl_irq)  lvl_seen++;
    endtask

    task automatic read_byte();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_wr = 0; cfg_size = 0; hold_en = 0; fifo_clr = 0;
        start_req = 0; byte_vld = 0; byte_data = 0; rd_en = 0;
        repeat (3) tick();
        // R1 reset state
        check(!bus_busy && xfer_left == 0 && !rx_avail && !scl_stall && !rx_ack,
              "R1 idle outputs", {bus_busy, rx_avail, scl_stall, rx_ack}, 0);
        check(!lvl_irq && !done_irq && !ovf_irq && !unf_irq, "R1 pulses",
              {lvl_irq, done_irq, ovf_irq, unf_irq}, 0);
        rst_n = 1'b1;
        tick();

        // R2 start with zero count is ignored
        pulse_start();
        check(!bus_busy, "R2 zero-count start", bus_busy, 0);

        // table-driven receive transfers
        foreach (VEC[v]) begin
            automatic int  sz   = int'(VEC[v][10:3]);
            automatic bit  hd   = VEC[v][2];
            automatic int  elvl = int'(VEC[v][1]);
            automatic int  edn  = int'(VEC[v][0]);
            automatic int  bad  = 0;
            hold_en = hd;
            load_count(8'(sz));
            check(xfer_left == 8'(sz), "R2 count load", xfer_left, sz);
            pulse_start();
            check(bus_busy, "R2 start busy", bus_busy, 1);
            acks = 0; done_seen = 0; lvl_seen = 0;
            for (int i = 0; i < sz; i++) send_byte(8'(sz * 7 + i * 3));
            tick();
            if (done_irq) done_seen++;
            check(acks == sz - 1 && !last_ack, "R4 ack pattern", acks, sz - 1);
            check(xfer_left == 0, "R3 count reaches zero", xfer_left, 0);
            check(bus_busy == hd, "R5 R6 bus after count end", bus_busy, hd);
            check(done_seen == edn, "R5 R6 completion pulses", done_seen, edn);
            check(lvl_seen == elvl, "R8 level pulses", lvl_seen, elvl);
            check(scl_stall == (hd && sz == 16), "R9 stall at full", scl_stall,
                  hd && sz == 16);
            if (hd) begin
                hold_en = 1'b0;
                tick();
                check(!bus_busy && !done_irq, "R6 release without completion",
                      {bus_busy, done_irq}, 0);
            end
            for (int i = 0; i < sz; i++) begin
                if (!rx_avail || rd_data != 8'(sz * 7 + i * 3)) bad++;
                read_byte();
            end
            check(bad == 0, "R7 data order", bad, 0);
            check(!rx_avail, "R7 drained", rx_avail, 0);
        end

        // R3 byte strobe while idle is ignored
        load_count(8'd3);
        send_byte(8'h55);
        check(xfer_left == 3 && !rx_avail, "R3 idle byte ignored", xfer_left, 3);

        // R10 overflow with hold clear, R12 clear
        hold_en = 1'b0;
        load_count(8'd20);
        pulse_start();
        for (int i = 0; i < 16; i++) send_byte(8'(8'hA0 + i));
        check(!scl_stall, "R9 no stall without hold", scl_stall, 0);
        send_byte(8'hEE);
        check(ovf_irq, "R10 overflow pulse", ovf_irq, 1);
        check(xfer_left == 3, "R10 count still drops", xfer_left, 3);
        check(rd_data == 8'hA0, "R10 stored bytes intact", rd_data, 8'hA0);
        fifo_clr = 1'b1; tick(); fifo_clr = 1'b0;
        check(!rx_avail, "R12 clear empties", rx_avail, 1'b0);
        for (int i = 0; i < 3; i++) send_byte(8'h11);
        check(!bus_busy, "R5 overflow transfer finishes", bus_busy, 0);
        fifo_clr = 1'b1; tick(); fifo_clr = 1'b0;

        // R9 stall with hold, relief by one read; R4 nack under hold
        hold_en = 1'b1;
        load_count(8'd17);
        pulse_start();
        for (int i = 0; i < 16; i++) send_byte(8'(i));
        check(scl_stall, "R9 stall when full", scl_stall, 1);
        read_byte();
        check(!scl_stall, "R9 stall drops after read", scl_stall, 0);
        check(!rx_ack, "R4 nack with hold set", rx_ack, 0);
        send_byte(8'h77);
        check(bus_busy, "R6 parked", bus_busy, 1);

        // R6 repeated start from park
        fifo_clr = 1'b1; cfg_wr = 1'b1; cfg_size = 8'd2; tick();
        fifo_clr = 1'b0; cfg_wr = 1'b0;
        pulse_start();
        check(bus_busy, "R6 repeated start keeps bus", bus_busy, 1);
        done_seen = 0;
        send_byte(8'h01); send_byte(8'h02);
        check(bus_busy && done_seen == 0, "R6 parked again", done_seen, 0);
        hold_en = 1'b0;
        tick();
        check(!bus_busy, "R6 release", bus_busy, 0);
        read_byte(); read_byte();

        // R11 underflow
        read_byte();
        check(unf_irq && !rx_avail, "R11 underflow pulse", unf_irq, 1);
        tick();
        check(!unf_irq, "R11 pulse one cycle", unf_irq, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule